// File: doc/BRIEF.md
# Serial EEPROM Address Pointer with Block-Confined Reads

This block tracks the internal memory address of a two-wire serial memory slave. A bit-level bus engine in front of it turns bus activity into single-cycle byte events: a start (or repeated start) condition, the device-select byte, the word-address byte, each transferred data byte together with its direction, and a stop condition. From these events the block decides whether the device is being addressed, assembles a 10-bit memory address from the block, page and byte fields, and moves that address forward after every data byte.

Reads and writes move through memory in different ways. A write stays inside one 16-byte page: after the last byte of the page, the address goes back to the start of that page. A sequential read stays inside one 128-byte block: after the last byte of the block, the address goes back to the start of that block. A read never changes the block. The block bits carried in a read's select byte are ignored, so the block chosen by the most recent write command stays in force. If a write command carries more than one page's worth of data, earlier bytes in the page are overwritten. The block raises a flag when this happens, and the flag stays up until the next start condition.

The device answers only to select codes whose top five bits are 1,0,1,0,1, which is A8h to AFh. A write command that carries only the address bytes and is then followed by a repeated start loads the pointer and writes nothing. This is how a random read is set up.

Top module: `eeptr_top`

## Requirements
- R1: One cycle after a select event, `sel_match` is 1 exactly when `sel_byte[7:3]` equals 5'b10101 (codes A8h to AFh). It goes back to 0 one cycle after a start or stop event.
- R2: A matching write select (`sel_byte[0]`=0) followed by a word-address event loads `mem_addr` = {`sel_byte[2:1]`, `word_byte[7:0]`}. That is block = {sel[2:1], word[7]}, page = word[6:4], byte = word[3:0], and the address equals block*128 + page*16 + byte.
- R3: A matching read select (`sel_byte[0]`=1) leaves `mem_addr` unchanged, whatever `sel_byte[2:1]` holds. Reads use the block loaded by the last write command.
- R4: In a read phase, each read data event sets `mem_addr` to {block, (offset+1) mod 128}, where offset is `mem_addr[6:0]`. The block bits `mem_addr[9:7]` never change.
- R5: In a write phase after the word address, each write data event sets `mem_addr` to {`mem_addr[9:4]`, (byte+1) mod 16}. The page and block bits never change.
- R6: After a word-address load, the 17th and every later write data event sets `wr_overflow`. The first 16 write data events leave it 0. A start event clears it.
- R7: While `rst_n` or `pwr_good` is low, the next clock edge clears `mem_addr` to 0 and clears `sel_match` and `wr_overflow`.
- R8: When a write command that carries only the address bytes is followed by a repeated start, `mem_addr` keeps the loaded value.
- R9: The following events leave `mem_addr` unchanged: data events when no matching command is active, word-address events outside the word-address phase, and data events whose direction does not match the command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_good | input | 1 | Power-good; low holds the logic in reset |
| evt_start | input | 1 | Start or repeated-start event pulse |
| evt_stop | input | 1 | Stop event pulse |
| evt_sel | input | 1 | Device-select byte received |
| sel_byte | input | 8 | Device-select byte value |
| evt_word | input | 1 | Word-address byte received |
| word_byte | input | 8 | Word-address byte value |
| evt_data | input | 1 | Data byte transferred |
| data_rd | input | 1 | Direction of the data byte (1 = read) |
| mem_addr | output | 10 | Current memory address |
| sel_match | output | 1 | Device selected by the current command |
| wr_overflow | output | 1 | More than 16 data bytes in the current write |

## Verification
Some properties are checked by assertions on every cycle. A read advance never changes the block bits. A write advance never changes the page and block bits. A non-matching select always drops `sel_match`. A start always clears the overflow flag. A low power-good always forces the address to zero. Other behaviour can only be shown by the bench's scenarios, which sweep all 256 select codes and all 1024 loadable addresses. These scenarios check the exact wrap points after 16 and 128 bytes, the block carried over from a write into a later read that sends different block bits, the exact byte on which overflow appears, and that a pointer loaded before a repeated start is kept.

// File: rtl/eeptr_pkg.sv
// Package: shared types for the serial EEPROM address pointer.
// Assumes byte events arrive as single-cycle pulses, at most one per cycle.
package eeptr_pkg;

    // Command phase of the slave between start and stop conditions
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,   // not addressed, or between commands
        PH_WADDR = 2'd1,   // write select matched, word address expected
        PH_WDATA = 2'd2,   // write data phase
        PH_RDATA = 2'd3    // read data phase
    } phase_e;

endpackage

// File: rtl/eeptr_phase_ctl.sv
// Module: eeptr_phase_ctl
// Decodes the device-select byte and runs the command phase. Produces the
// load and advance strobes for the address counter. Assumes rst_n is the
// combined reset (external reset and power-good) and events are one-hot.
module eeptr_phase_ctl
    import eeptr_pkg::*;
#(
    parameter int          PREFIX_W = 5,
    parameter logic [4:0]  PREFIX   = 5'b10101,
    parameter int          BLK_HI_W = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                evt_start,
    input  logic                evt_stop,
    input  logic                evt_sel,
    input  logic [7:0]          sel_byte,
    input  logic                evt_word,
    input  logic                evt_data,
    input  logic                data_rd,
    output logic                sel_match,
    output logic [BLK_HI_W-1:0] blk_hi,
    output logic                load,
    output logic                adv_wr,
    output logic                adv_rd
);
    localparam int HI_LSB = 1;
    localparam int HI_MSB = HI_LSB + BLK_HI_W - 1;

    phase_e phase_q;
    logic   hit;
    logic   is_read;

    // Compare the fixed select prefix (the third device bit is fixed high)
    assign hit     = (sel_byte[7 -: PREFIX_W] == PREFIX[PREFIX_W-1:0]);
    assign is_read = sel_byte[0];

    // Strobes for the counter, gated by the current phase
    always_comb begin
        load   = evt_word && (phase_q == PH_WADDR);
        adv_wr = evt_data && !data_rd && (phase_q == PH_WDATA);
        adv_rd = evt_data &&  data_rd && (phase_q == PH_RDATA);
    end

    // Phase, select-match and pending block-bit registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q   <= PH_IDLE;
            sel_match <= 1'b0;
            blk_hi    <= '0;
        end else if (evt_start || evt_stop) begin
            phase_q   <= PH_IDLE;
            sel_match <= 1'b0;
        end else if (evt_sel) begin
            sel_match <= hit;
            if (!hit) begin
                phase_q <= PH_IDLE;
            end else if (is_read) begin
                phase_q <= PH_RDATA;
            end else begin
                phase_q <= PH_WADDR;
                blk_hi  <= sel_byte[HI_MSB:HI_LSB];
            end
        end else if (load) begin
            phase_q <= PH_WDATA;
        end
    end

    AST_SEL_NOMATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_sel && !hit) |=> !sel_match); // R1
    AST_STOP_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_start || evt_stop) |=> !sel_match); // R1
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({load, adv_wr, adv_rd})); // R9

endmodule

// File: rtl/eeptr_addr_ctr.sv
// Module: eeptr_addr_ctr
// Holds the memory address. It loads a full address on command and advances
// either within the page (writes) or within the block (reads). Assumes at
// most one of load, adv_wr and adv_rd is high in a cycle.
module eeptr_addr_ctr #(
    parameter int BLK_W  = 3,
    parameter int PAGE_W = 3,
    parameter int BYTE_W = 4
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                load,
    input  logic [BLK_W+PAGE_W+BYTE_W-1:0]      load_val,
    input  logic                                adv_wr,
    input  logic                                adv_rd,
    output logic [BLK_W+PAGE_W+BYTE_W-1:0]      addr
);
    localparam int OFF_W  = PAGE_W + BYTE_W;
    localparam int ADDR_W = BLK_W + OFF_W;

    logic [BYTE_W-1:0] byte_inc;
    logic [OFF_W-1:0]  off_inc;

    // Incremented fields; the carry out is dropped so each wraps by itself
    always_comb begin
        byte_inc = addr[BYTE_W-1:0] + 1'b1;
        off_inc  = addr[OFF_W-1:0] + 1'b1;
    end

    // Address register: load, page-wrapped write advance, block-wrapped read advance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (load) begin
            addr <= load_val;
        end else if (adv_wr) begin
            addr[BYTE_W-1:0] <= byte_inc;
        end else if (adv_rd) begin
            addr[OFF_W-1:0] <= off_inc;
        end
    end

    AST_RD_KEEPS_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        adv_rd |=> addr[ADDR_W-1:OFF_W] == $past(addr[ADDR_W-1:OFF_W])); // R4
    AST_WR_KEEPS_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        adv_wr |=> addr[ADDR_W-1:BYTE_W] == $past(addr[ADDR_W-1:BYTE_W])); // R5
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(load || adv_wr || adv_rd) |=> $stable(addr)); // R9

endmodule

// File: rtl/eeptr_ovf_track.sv
// Module: eeptr_ovf_track
// Counts the write data bytes since the last word-address load and flags the
// first byte past one page. Assumes clr marks a start condition.
module eeptr_ovf_track #(
    parameter int PAGE_BYTES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic load,
    input  logic adv_wr,
    output logic overflow
);
    localparam int CNT_W = $clog2(PAGE_BYTES + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(PAGE_BYTES);

    logic [CNT_W-1:0] cnt;

    // Saturating byte counter and sticky overflow flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            overflow <= 1'b0;
        end else if (clr) begin
            cnt      <= '0;
            overflow <= 1'b0;
        end else if (load) begin
            cnt <= '0;
        end else if (adv_wr) begin
            if (cnt == CNT_FULL) begin
                overflow <= 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    AST_START_CLEARS_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !overflow); // R6
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !clr) |=> overflow); // R6

endmodule

// File: rtl/eeptr_top.sv
// Module: eeptr_top
// Address pointer for a two-wire serial memory slave. It takes byte-level
// events from a bus engine, decodes the select and word-address bytes and
// tracks the 10-bit memory address. Power-good low holds the logic in reset.
module eeptr_top #(
    parameter int BLK_W      = 3,
    parameter int PAGE_W     = 3,
    parameter int BYTE_W     = 4,
    parameter int WORD_W     = 8,
    parameter int PAGE_BYTES = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          pwr_good,
    input  logic                          evt_start,
    input  logic                          evt_stop,
    input  logic                          evt_sel,
    input  logic [7:0]                    sel_byte,
    input  logic                          evt_word,
    input  logic [WORD_W-1:0]             word_byte,
    input  logic                          evt_data,
    input  logic                          data_rd,
    output logic [BLK_W+PAGE_W+BYTE_W-1:0] mem_addr,
    output logic                          sel_match,
    output logic                          wr_overflow
);
    localparam int ADDR_W   = BLK_W + PAGE_W + BYTE_W;
    localparam int BLK_HI_W = ADDR_W - WORD_W;

    logic                srst_n;
    logic [BLK_HI_W-1:0] blk_hi;
    logic                load;
    logic                adv_wr;
    logic                adv_rd;
    logic [ADDR_W-1:0]   load_val;

    // Combined reset: external reset or missing power
    assign srst_n   = rst_n && pwr_good;
    // Full load value: block high bits from the select byte, rest from the word byte
    assign load_val = {blk_hi, word_byte};

    eeptr_phase_ctl #(
        .PREFIX_W (5),
        .PREFIX   (5'b10101),
        .BLK_HI_W (BLK_HI_W)
    ) phase_i (
        .clk       (clk),
        .rst_n     (srst_n),
        .evt_start (evt_start),
        .evt_stop  (evt_stop),
        .evt_sel   (evt_sel),
        .sel_byte  (sel_byte),
        .evt_word  (evt_word),
        .evt_data  (evt_data),
        .data_rd   (data_rd),
        .sel_match (sel_match),
        .blk_hi    (blk_hi),
        .load      (load),
        .adv_wr    (adv_wr),
        .adv_rd    (adv_rd)
    );

    eeptr_addr_ctr #(
        .BLK_W  (BLK_W),
        .PAGE_W (PAGE_W),
        .BYTE_W (BYTE_W)
    ) ctr_i (
        .clk      (clk),
        .rst_n    (srst_n),
        .load     (load),
        .load_val (load_val),
        .adv_wr   (adv_wr),
        .adv_rd   (adv_rd),
        .addr     (mem_addr)
    );

    eeptr_ovf_track #(
        .PAGE_BYTES (PAGE_BYTES)
    ) ovf_i (
        .clk      (clk),
        .rst_n    (srst_n),
        .clr      (evt_start),
        .load     (load),
        .adv_wr   (adv_wr),
        .overflow (wr_overflow)
    );

    AST_PWR_LOW_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good |=> (mem_addr == '0 && !sel_match && !wr_overflow)); // R7

endmodule

// File: tb/eeptr_top_tb_top.sv
// Bench for eeptr_top: sweeps select codes and load addresses, then walks
// reads and writes across their wrap points with arithmetic expectations.
module eeptr_top_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwr_good = 1'b1;
    logic       evt_start = 1'b0, evt_stop = 1'b0, evt_sel = 1'b0;
    logic       evt_word = 1'b0, evt_data = 1'b0, data_rd = 1'b0;
    logic [7:0] sel_byte = '0, word_byte = '0;
    logic [9:0] mem_addr;
    logic       sel_match, wr_overflow;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    eeptr_top dut_i (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good),
        .evt_start(evt_start), .evt_stop(evt_stop),
        .evt_sel(evt_sel), .sel_byte(sel_byte),
        .evt_word(evt_word), .word_byte(word_byte),
        .evt_data(evt_data), .data_rd(data_rd),
        .mem_addr(mem_addr), .sel_match(sel_match), .wr_overflow(wr_overflow)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Each event is held for one clock edge; outputs are read at the next negedge
    task automatic do_start();
        @(negedge clk); evt_start = 1; @(negedge clk); evt_start = 0;
    endtask
    task automatic do_stop();
        @(negedge clk); evt_stop = 1; @(negedge clk); evt_stop = 0;
    endtask
    task automatic do_sel(input logic [7:0] b);
        @(negedge clk); evt_sel = 1; sel_byte = b; @(negedge clk); evt_sel = 0;
    endtask
    task automatic do_word(input logic [7:0] b);
        @(negedge clk); evt_word = 1; word_byte = b; @(negedge clk); evt_word = 0;
    endtask
    task automatic do_data(input logic rd);
        @(negedge clk); evt_data = 1; data_rd = rd; @(negedge clk); evt_data = 0;
    endtask
    // Full address-setting write command (no data)
    task automatic set_ptr(input int a);
        do_start();
        do_sel({5'b10101, 2'(a >> 8), 1'b0});
        do_word(8'(a));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R7: reset state
        chk("R7 reset addr", int'(mem_addr), 0);
        chk("R7 reset match", int'(sel_match), 0);
        chk("R7 reset ovf", int'(wr_overflow), 0);
        rst_n = 1;

        // R1: every select code
        for (int s = 0; s < 256; s++) begin
            do_start();
            do_sel(8'(s));
            chk("R1 match", int'(sel_match), ((s >> 3) == 21) ? 1 : 0);
            do_stop();
            chk("R1 stop clears", int'(sel_match), 0);
        end

        // R2/R8: every loadable address, kept through a repeated start
        for (int a = 0; a < 1024; a++) begin
            set_ptr(a);
            chk("R2 load", int'(mem_addr), a);
            do_start();
            chk("R8 repeated start keeps", int'(mem_addr), a);
        end

        // R3/R4: read ignores select block bits and wraps in the block
        for (int a = 0; a < 1024; a += 173) begin
            set_ptr(a);
            do_start();
            do_sel({5'b10101, 2'(~(a >> 8)), 1'b1});
            chk("R3 read select keeps", int'(mem_addr), a);
            for (int k = 1; k <= 130; k++) begin
                do_data(1'b1);
                chk("R4 read advance", int'(mem_addr),
                    (a & 10'h380) | ((a + k) & 10'h07F));
            end
            do_stop();
        end

        // R5/R6: write wraps in the page, overflow on the 17th byte
        for (int a = 5; a < 1024; a += 211) begin
            set_ptr(a);
            for (int k = 1; k <= 20; k++) begin
                do_data(1'b0);
                chk("R5 write advance", int'(mem_addr),
                    (a & 10'h3F0) | ((a + k) & 10'h00F));
                chk("R6 overflow", int'(wr_overflow), (k > 16) ? 1 : 0);
            end
            do_stop();
            chk("R6 held past stop", int'(wr_overflow), 1);
            do_start();
            chk("R6 start clears", int'(wr_overflow), 0);
        end

        // R9: ignored events
        set_ptr(10'h155);
        do_data(1'b1);
        chk("R9 wrong-direction data", int'(mem_addr), 10'h155);
        do_word(8'h00);
        chk("R9 second word byte", int'(mem_addr), 10'h155);
        do_stop();
        do_data(1'b0);
        do_data(1'b1);
        chk("R9 data while idle", int'(mem_addr), 10'h155);
        do_start();
        do_sel(8'hA1);
        do_word(8'h00);
        do_data(1'b1);
        chk("R9 non-matching select", int'(mem_addr), 10'h155);
        do_start();
        do_sel(8'hAB);
        do_word(8'h22);
        chk("R9 word in read phase", int'(mem_addr), 10'h155);

        // R7: power-good low forces reset
        set_ptr(10'h2C7);
        @(negedge clk); pwr_good = 0; @(negedge clk);
        chk("R7 power low addr", int'(mem_addr), 0);
        chk("R7 power low match", int'(sel_match), 0);
        pwr_good = 1;
        do_data(1'b0);
        chk("R7 idle after power", int'(mem_addr), 0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule